// File: doc/BRIEF.md
# Satellite Control Message Sender

This block drives the control line that a dish receiver uses to talk to its outdoor equipment. It keys a 22 kHz square-wave carrier on and off to produce three kinds of signal: a steady tone, a short tone burst in one of two forms, and command messages of three to six bytes. Each message bit carries a parity bit after every byte. The block also holds the supply-voltage select for the low-noise block, 13 V or 18 V.

A host writes the message bytes into a small bank of registers, sets a mode bit to choose between a message and a burst, and then writes a command register. The command register carries the length code, the burst choice, the steady-tone enable, the voltage select and a go bit. All timing is built from slots of half a millisecond. A send begins on the next slot boundary after it is accepted. Each send ends with a 15 ms silent gap, after which `ready` returns high and the steady tone, if enabled, comes back.

The carrier is derived from the system clock by the `HALF_DIV` parameter, which gives the number of clocks per carrier half-period. `PERIODS_PER_SLOT` gives the number of carrier periods in one slot.

Top module: `sat_ctl_sender`

## Requirements
- R1: After reset `tone_out` is 0, `ready` is 1 and `lnb_18v` is 0 (13 V).
- R2: Whenever the envelope is on, `tone_out` is a square wave with a period of 2*HALF_DIV clocks. It is high for the first HALF_DIV clocks of each period, and its phase is locked to a free-running slot grid of 2*HALF_DIV*PERIODS_PER_SLOT clocks that starts at reset.
- R3: Bit 4 of the command register (address 6) enables the steady tone. While no send is in progress, a change of this bit reaches `tone_out` at the next slot boundary.
- R4: Message bytes sit at addresses 0 to 5. Byte 0 is sent first, each byte MSB first, and each byte is followed by an odd-parity bit. The byte count is 3 plus command bits [1:0].
- R5: Each bit lasts 3 slots. A 0 is two slots of tone followed by one silent slot. A 1 is one slot of tone followed by two silent slots.
- R6: Bit 2 of the mode register (address 7) set to 1 selects burst mode. In burst mode, command bit 3 = 0 sends 25 slots of unbroken tone, and bit 3 = 1 sends nine 1-bits.
- R7: A command write with bit 6 set, made while `ready` is 1, is accepted. `ready` drops after that clock edge, and the send starts at the next slot boundary.
- R8: Every send is followed by 30 silent slots. Then `ready` returns to 1, and the steady tone resumes if it is enabled.
- R9: A command write with bit 6 set while `ready` is 0 starts no further send.
- R10: A command write with bit 6 set loads `lnb_18v` with the inverse of bit 7: [7:6] = 11b selects 13 V and 01b selects 18V. A command write with bit 6 clear leaves `lnb_18v` unchanged.
- R11: The length, mode and burst choice are captured when a send is accepted. Command or mode writes made during the send do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address: 0-5 message bytes, 6 command, 7 mode |
| wr_data | input | 8 | Write data |
| tone_out | output | 1 | Keyed 22 kHz carrier to the line driver |
| ready | output | 1 | High when a new send may be accepted |
| lnb_18v | output | 1 | Supply select: 1 = 18 V, 0 = 13 V |

## Verification
The hardest cases to reach are writes that land while a send is already running. These include a second go, a changed length code and a voltage change during a six-byte message. The bench issues these writes in the middle of a long message and checks two things: the waveform still matches the length captured at acceptance, and no extra send follows the gap. A behavioural model rebuilds the expected slot sequence as a queue and compares the line on every clock. This lets byte order, parity, the bit shapes, the burst forms and the exact cycle at which the steady tone returns all be checked across every phase of the slot grid.

// File: rtl/sat_ctl_pkg.sv
package sat_ctl_pkg;

    localparam int MSG_BYTES = 6;
    localparam logic [3:0] ADDR_CMD  = 4'd6;
    localparam logic [3:0] ADDR_MODE = 4'd7;

    typedef logic [7:0] byte_t;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_BITS  = 2'd1,
        SQ_BURST = 2'd2,
        SQ_GAP   = 2'd3
    } seq_st_t;

    typedef struct packed {
        logic       burst;
        logic       sel_b;
        logic [1:0] len_code;
    } job_t;

    function automatic logic odd_parity(input byte_t b);
        return ~^b;
    endfunction

    // slot 0 always keyed, slot 1 keyed only for a zero, slot 2 silent
    function automatic logic bit_slot_level(input logic b, input logic [1:0] sub);
        return (sub == 2'd0) || ((sub == 2'd1) && !b);
    endfunction

endpackage

// File: rtl/sat_tone_timebase.sv
module sat_tone_timebase #(
    parameter int HALF_DIV         = 614,
    parameter int PERIODS_PER_SLOT = 11
) (
    input  logic clk,
    input  logic rst,
    output logic carrier,
    output logic slot_tick
);
    localparam int HALF_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam int HALVES = 2 * PERIODS_PER_SLOT;
    localparam int IDX_W  = (HALVES > 1) ? $clog2(HALVES) : 1;

    logic [HALF_W-1:0] half_cnt;
    logic [IDX_W-1:0]  half_idx;
    logic              half_wrap;

    assign half_wrap = (half_cnt == HALF_W'(HALF_DIV - 1));
    assign slot_tick = half_wrap && (half_idx == IDX_W'(HALVES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            half_cnt <= '0;
            half_idx <= '0;
            carrier  <= 1'b1;
        end else if (half_wrap) begin
            half_cnt <= '0;
            carrier  <= ~carrier;
            half_idx <= (half_idx == IDX_W'(HALVES - 1)) ? '0 : half_idx + 1'b1;
        end else begin
            half_cnt <= half_cnt + 1'b1;
        end
    end

    AST_CARRIER_ON_HALF: assert property (@(posedge clk) disable iff (rst)
        (carrier != $past(carrier)) |-> $past(half_wrap)); // R2

endmodule

// File: rtl/sat_ctl_regs.sv
module sat_ctl_regs
    import sat_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [3:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       idle,
    input  logic       start,
    output byte_t      msg_q [MSG_BYTES],
    output logic       tone_en,
    output job_t       job,
    output logic       pend,
    output logic       lnb_18v,
    output logic       ready
);
    logic mode_burst;
    logic unused_bit5;

    assign unused_bit5 = wr_data[5];
    assign ready = idle && !pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MSG_BYTES; i++) msg_q[i] <= '0;
            tone_en    <= 1'b0;
            job        <= '0;
            pend       <= 1'b0;
            lnb_18v    <= 1'b0;
            mode_burst <= 1'b0;
        end else begin
            if (start) pend <= 1'b0;
            if (wr_en) begin
                if (wr_addr < 4'(MSG_BYTES)) msg_q[wr_addr[2:0]] <= wr_data;
                if (wr_addr == ADDR_MODE) mode_burst <= wr_data[2];
                if (wr_addr == ADDR_CMD) begin
                    tone_en <= wr_data[4];
                    if (wr_data[6]) begin
                        lnb_18v <= ~wr_data[7];
                        if (ready) begin
                            pend <= 1'b1;
                            job  <= '{burst: mode_burst, sel_b: wr_data[3],
                                      len_code: wr_data[1:0]};
                        end
                    end
                end
            end
        end
    end

    AST_GO_ONLY_READY: assert property (@(posedge clk) disable iff (rst)
        $rose(pend) |-> $past(idle)); // R9

    AST_VOLT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (lnb_18v != $past(lnb_18v)) |->
            $past(wr_en && (wr_addr == ADDR_CMD) && wr_data[6])); // R10

endmodule

// File: rtl/sat_frame_seq.sv
module sat_frame_seq
    import sat_ctl_pkg::*;
#(
    parameter int BURST_SLOTS = 25,
    parameter int GAP_SLOTS   = 30
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  slot_tick,
    input  logic  tone_en,
    input  logic  pend,
    input  job_t  job,
    input  byte_t msg_q [MSG_BYTES],
    output logic  idle,
    output logic  start,
    output logic  env_q
);
    localparam int MAXC  = (BURST_SLOTS > GAP_SLOTS) ? BURST_SLOTS : GAP_SLOTS;
    localparam int CNT_W = $clog2(MAXC + 1);

    seq_st_t          st, n_st;
    logic [1:0]       sub, n_sub;
    logic [3:0]       bitn, n_bitn;
    logic [2:0]       byten, n_byten;
    logic [CNT_W-1:0] cnt, n_cnt;
    logic [2:0]       last_byte, bsel;
    logic             cur_bit, level;

    assign idle  = (st == SQ_IDLE);
    assign start = slot_tick && idle && pend;
    assign last_byte = job.burst ? 3'd0 : ({1'b0, job.len_code} + 3'd2);

    always_comb begin
        n_st = st; n_sub = sub; n_bitn = bitn; n_byten = byten; n_cnt = cnt;
        unique case (st)
            SQ_IDLE: if (pend) begin
                n_sub = '0; n_bitn = '0; n_byten = '0; n_cnt = '0;
                n_st  = (job.burst && !job.sel_b) ? SQ_BURST : SQ_BITS;
            end
            SQ_BITS: if (sub != 2'd2) begin
                n_sub = sub + 1'b1;
            end else begin
                n_sub = '0;
                if (bitn != 4'd8) begin
                    n_bitn = bitn + 1'b1;
                end else begin
                    n_bitn = '0;
                    if (byten == last_byte) begin
                        n_st = SQ_GAP; n_cnt = '0;
                    end else begin
                        n_byten = byten + 1'b1;
                    end
                end
            end
            SQ_BURST: if (cnt == CNT_W'(BURST_SLOTS - 1)) begin
                n_st = SQ_GAP; n_cnt = '0;
            end else begin
                n_cnt = cnt + 1'b1;
            end
            SQ_GAP: if (cnt == CNT_W'(GAP_SLOTS - 1)) begin
                n_st = SQ_IDLE; n_cnt = '0;
            end else begin
                n_cnt = cnt + 1'b1;
            end
            default: n_st = SQ_IDLE;
        endcase
    end

    always_comb begin
        bsel = 3'd7 - n_bitn[2:0];
        if (job.burst)          cur_bit = 1'b1;
        else if (n_bitn == 4'd8) cur_bit = odd_parity(msg_q[n_byten]);
        else                    cur_bit = msg_q[n_byten][bsel];
        unique case (n_st)
            SQ_IDLE:  level = tone_en;
            SQ_BITS:  level = bit_slot_level(cur_bit, n_sub);
            SQ_BURST: level = 1'b1;
            default:  level = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= SQ_IDLE; sub <= '0; bitn <= '0; byten <= '0; cnt <= '0;
            env_q <= 1'b0;
        end else if (slot_tick) begin
            st <= n_st; sub <= n_sub; bitn <= n_bitn; byten <= n_byten; cnt <= n_cnt;
            env_q <= level;
        end
    end

    AST_START_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        ((st != SQ_IDLE) && ($past(st) == SQ_IDLE)) |-> $past(slot_tick && pend)); // R7

    AST_ENV_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (env_q != $past(env_q)) |-> $past(slot_tick)); // R5

    AST_GAP_SILENT: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_GAP) |-> !env_q); // R8

endmodule

// File: rtl/sat_ctl_sender.sv
module sat_ctl_sender
    import sat_ctl_pkg::*;
#(
    parameter int HALF_DIV         = 614,
    parameter int PERIODS_PER_SLOT = 11,
    parameter int BURST_SLOTS      = 25,
    parameter int GAP_SLOTS        = 30
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [3:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic       tone_out,
    output logic       ready,
    output logic       lnb_18v
);
    logic  carrier, slot_tick, tone_en, pend, idle, start, env_q;
    job_t  job;
    byte_t msg_q [MSG_BYTES];

    sat_tone_timebase #(.HALF_DIV(HALF_DIV), .PERIODS_PER_SLOT(PERIODS_PER_SLOT)) u_tb (
        .clk(clk), .rst(rst), .carrier(carrier), .slot_tick(slot_tick));

    sat_ctl_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .idle(idle), .start(start), .msg_q(msg_q), .tone_en(tone_en), .job(job),
        .pend(pend), .lnb_18v(lnb_18v), .ready(ready));

    sat_frame_seq #(.BURST_SLOTS(BURST_SLOTS), .GAP_SLOTS(GAP_SLOTS)) u_seq (
        .clk(clk), .rst(rst), .slot_tick(slot_tick), .tone_en(tone_en), .pend(pend),
        .job(job), .msg_q(msg_q), .idle(idle), .start(start), .env_q(env_q));

    assign tone_out = env_q & carrier;

    AST_SILENT_AFTER_RESET: assert property (@(posedge clk)
        $fell(rst) |-> (!tone_out && ready && !lnb_18v)); // R1

endmodule

// File: tb/sat_ctl_sender_tb.sv
module sat_ctl_sender_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HD  = 2;
    localparam int PPS = 11;
    localparam int S   = 2 * HD * PPS;

    logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic tone_out, ready, lnb_18v;

    int n_checks = 0, n_fail = 0;
    bit done = 1'b0;

    sat_ctl_sender #(.HALF_DIV(HD), .PERIODS_PER_SLOT(PPS)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .tone_out(tone_out), .ready(ready), .lnb_18v(lnb_18v));

    always #(CLK_PERIOD / 2) clk = ~clk;

    // behavioural reference model
    int k;
    bit m_env, m_busy, m_pend, m_tone, m_lnb, m_mode, m_jb, m_jsel;
    int m_jlen;
    bit [7:0] m_msg [6];
    int q[$];
    string m_ctx = "R1";

    task automatic push_bit(input bit b);
        q.push_back(1); q.push_back(b ? 0 : 1); q.push_back(0);
    endtask

    task automatic build_queue();
        q.delete();
        if (m_jb && !m_jsel) begin
            for (int i = 0; i < 25; i++) q.push_back(1);
            m_ctx = "R6";
        end else if (m_jb) begin
            for (int i = 0; i < 9; i++) push_bit(1'b1);
            m_ctx = "R6";
        end else begin
            for (int by = 0; by < m_jlen; by++) begin
                for (int b = 7; b >= 0; b--) push_bit(m_msg[by][b]);
                push_bit(~^m_msg[by]);
            end
            m_ctx = "R4";
        end
        for (int i = 0; i < 30; i++) q.push_back(0);
    endtask

    always @(posedge clk) begin
        if (rst) begin
            k = 0; m_env = 0; m_busy = 0; m_pend = 0; m_tone = 0; m_lnb = 0; m_mode = 0;
            m_jb = 0; m_jsel = 0; m_jlen = 3; q.delete(); m_ctx = "R1";
            for (int i = 0; i < 6; i++) m_msg[i] = 8'h00;
        end else begin
            bit rdy_old;
            rdy_old = !m_busy && !m_pend;
            if (k == S - 1) begin
                k = 0;
                if (m_busy) begin
                    if (q.size() > 0) m_env = q.pop_front();
                    else begin m_busy = 0; m_env = m_tone; m_ctx = "R8"; end
                end else if (m_pend) begin
                    build_queue(); m_pend = 0; m_busy = 1; m_env = q.pop_front();
                end else begin
                    m_env = m_tone;
                end
            end else begin
                k++;
            end
            if (wr_en) begin
                if (wr_addr < 6) m_msg[wr_addr] = wr_data;
                if (wr_addr == 7) m_mode = wr_data[2];
                if (wr_addr == 6) begin
                    m_tone = wr_data[4];
                    if (wr_data[6]) begin
                        m_lnb = ~wr_data[7];
                        if (rdy_old) begin
                            m_pend = 1; m_jb = m_mode; m_jsel = wr_data[3];
                            m_jlen = 3 + int'(wr_data[1:0]);
                        end
                    end
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            if (n_fail < 20)
                $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model (R2 carrier shape, R3/R5 envelope)
    always @(negedge clk) begin
        if (!rst && !done) begin
            bit carr, exp_tone;
            carr = ((k / HD) % 2) == 0;
            exp_tone = m_env && carr;
            check(tone_out == exp_tone, m_ctx == "R1" ? "R2" : m_ctx, "tone_out",
                  int'(tone_out), int'(exp_tone));
            check(ready == (!m_busy && !m_pend), "R7", "ready",
                  int'(ready), int'(!m_busy && !m_pend));
            check(lnb_18v == m_lnb, "R10", "lnb_18v", int'(lnb_18v), int'(m_lnb));
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic wait_ready(input string req);
        int n = 0;
        while (!ready && n < 20000) begin @(negedge clk); n++; end
        check(ready == 1'b1, req, "ready after send", int'(ready), 1);
    endtask

    task automatic wait_slots(input int n);
        repeat (n * S) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(tone_out == 1'b0, "R1", "tone_out after reset", int'(tone_out), 0);
        check(ready == 1'b1, "R1", "ready after reset", int'(ready), 1);
        check(lnb_18v == 1'b0, "R1", "lnb_18v after reset", int'(lnb_18v), 0);

        // R3: steady tone on, then off
        wr(4'd6, 8'h10);
        wait_slots(3);
        wr(4'd6, 8'h00);
        wait_slots(2);
        wr(4'd6, 8'h10);
        wait_slots(2);

        // R4/R5: three-byte message, tone on, 18 V
        wr(4'd0, 8'hA5); wr(4'd1, 8'h00); wr(4'd2, 8'hFF);
        wr(4'd6, 8'h50);
        check(ready == 1'b0, "R7", "ready after go", int'(ready), 0);
        wait_ready("R8");
        wait_slots(2);

        // six-byte message at 13 V, then writes during the send (R9, R10, R11)
        wr(4'd3, 8'h3C); wr(4'd4, 8'h81); wr(4'd5, 8'h7E);
        wr(4'd6, 8'hC3);
        check(lnb_18v == 1'b0, "R10", "13V select", int'(lnb_18v), 0);
        wait_slots(20);
        wr(4'd6, 8'h41);
        check(lnb_18v == 1'b1, "R10", "18V select while busy", int'(lnb_18v), 1);
        wr(4'd7, 8'h04);
        wait_ready("R11");
        wait_slots(3);
        check(ready == 1'b1, "R9", "no extra send", int'(ready), 1);

        // R6: burst A then burst B, tone enabled
        wr(4'd6, 8'h50);
        wait_ready("R6");
        wait_slots(2);
        wr(4'd6, 8'h58);
        wait_ready("R6");
        wait_slots(2);

        // R10: bit 6 clear leaves voltage, turns tone off
        wr(4'd6, 8'h80);
        wait_slots(1);
        check(lnb_18v == 1'b1, "R10", "voltage hold", int'(lnb_18v), 1);

        // R4: four- and five-byte messages
        wr(4'd7, 8'h00);
        wr(4'd6, 8'h41);
        wait_ready("R4");
        wr(4'd6, 8'h52);
        wait_ready("R4");
        wait_slots(3);
        finish_run();
    end
endmodule